// File: doc/BRIEF.md
# Multi-Carrier I/Q Power Limiter

This block sits in a streaming transmit path and scales complex baseband samples that arrive interleaved for up to four carriers. Each accepted sample carries a carrier index. The block tracks a running average of signal power for each carrier. It expresses that average in quarter-decibel attenuation below full scale, found through a table indexed by leading-one position and mantissa. It then picks the larger of two attenuations: the one the carrier is programmed for, and the one needed to keep the carrier under its programmed power ceiling. The chosen attenuation becomes a linear amplitude factor, and both the in-phase and the quadrature component are multiplied by it.

Configuration is static and per carrier. There is a requested attenuation, a power ceiling and a signed calibration offset, all in quarter-dB steps. The scaled result is rounded and clamped so that its magnitude never reaches 1.0 in Q1.15. Each result leaves a fixed six cycles after its input, together with a valid flag. There is no back-pressure.

Top module: `iq_power_limiter`

## Requirements
- R1: A sample accepted with `in_valid` high at a rising edge shows up with `out_valid` high exactly 6 rising edges later. `out_valid` is low in every other cycle.
- R2: On each accepted sample, only the accumulator of that sample's carrier changes. It becomes acc − (acc >> K) + ((I² + Q²) >> K), with K = 2, as an unsigned 32-bit value. The accumulators of the other carriers keep their values.
- R3: The updated accumulator is mapped to a measured attenuation att = 12·(31 − p) − F[m], in quarter-dB. Here p is the bit index of the leading one and m is the 3 bits just below it, with zeros filled in below bit 0. F = {0,2,4,6,7,8,10,11} for m = 0..7. An accumulator of zero maps to 384.
- R4: The applied attenuation is max(gain, limit − att − offset), clamped to the range 0..192 quarter-dB. The offset is two's complement.
- R5: An applied attenuation a = 24·s + r with 0 ≤ r < 24 gives the amplitude factor B[r] >> s. B[0] = 32767, and B[r] = round(32767·10^(−r/80)).
- R6: Each output component equals floor((x·L + 16384) / 32768), saturated to ±32767. The value −32768 never appears on a valid output.
- R7: While reset is asserted, all accumulators and the output pipeline are cleared. After reset, the outputs are zero and invalid.
- R8: Each sample is scaled using only its own carrier's gain, limit and offset. The settings of the other carriers have no effect on it.
- R9: `out_i` and `out_q` are zero in every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_car | input | 2 | Carrier index of the input sample |
| in_i | input | 16 | In-phase sample, signed Q1.15 |
| in_q | input | 16 | Quadrature sample, signed Q1.15 |
| cfg_gain | input | 4×8 | Requested attenuation per carrier, quarter-dB |
| cfg_limit | input | 4×10 | Power ceiling per carrier, quarter-dB below full scale |
| cfg_offset | input | 4×8 | Signed calibration offset per carrier, quarter-dB |
| out_valid | output | 1 | Output sample present |
| out_i | output | 16 | Scaled in-phase result, signed Q1.15 |
| out_q | output | 16 | Scaled quadrature result, signed Q1.15 |

## Verification
Every result of this block, including the accumulator update that feeds its own scaling, is due on the sixth rising edge after the input is sampled. The bench drives one sample per falling edge and logs the expected output in a ring indexed by cycle number. Six falling edges later it compares the ports against that entry, so each check lands on the exact cycle its result is due. Idle cycles, reset cycles and the cycles just after reset are expected to show zero outputs with valid low. Configuration changes only after six idle cycles, so that no sample in flight sees a mix of old and new settings.

// File: rtl/iqpl_pkg.sv
package iqpl_pkg;

    localparam int QDB_PER_OCT  = 12;   // quarter-dB per doubling of power
    localparam int QDB_PER_HALF = 24;   // quarter-dB per halving of amplitude
    localparam int QDB_MAX      = 192;  // 48 dB attenuation ceiling
    localparam int FRAC_BITS    = 3;    // mantissa bits used in the log table

    // fractional octave (power) in quarter-dB for mantissa 1.m
    function automatic logic [3:0] oct_frac(input logic [FRAC_BITS-1:0] m);
        case (m)
            3'd0:    return 4'd0;
            3'd1:    return 4'd2;
            3'd2:    return 4'd4;
            3'd3:    return 4'd6;
            3'd4:    return 4'd7;
            3'd5:    return 4'd8;
            3'd6:    return 4'd10;
            default: return 4'd11;
        endcase
    endfunction

    // amplitude factor for attenuation r quarter-dB, r < 24, Q0.15
    function automatic logic [14:0] lin_base(input logic [4:0] r);
        case (r)
            5'd0:    return 15'd32767;
            5'd1:    return 15'd31837;
            5'd2:    return 15'd30934;
            5'd3:    return 15'd30056;
            5'd4:    return 15'd29204;
            5'd5:    return 15'd28375;
            5'd6:    return 15'd27570;
            5'd7:    return 15'd26788;
            5'd8:    return 15'd26028;
            5'd9:    return 15'd25289;
            5'd10:   return 15'd24572;
            5'd11:   return 15'd23875;
            5'd12:   return 15'd23197;
            5'd13:   return 15'd22539;
            5'd14:   return 15'd21900;
            5'd15:   return 15'd21278;
            5'd16:   return 15'd20675;
            5'd17:   return 15'd20088;
            5'd18:   return 15'd19518;
            5'd19:   return 15'd18964;
            5'd20:   return 15'd18426;
            5'd21:   return 15'd17903;
            5'd22:   return 15'd17395;
            default: return 15'd16902;
        endcase
    endfunction

endpackage

// File: rtl/iqpl_pwr_track.sv
module iqpl_pwr_track #(
    parameter int NUM_CAR   = 4,
    parameter int ACC_W     = 32,
    parameter int ACC_SHIFT = 2,
    localparam int CAR_W    = (NUM_CAR > 1) ? $clog2(NUM_CAR) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic [CAR_W-1:0] upd_car,
    input  logic [ACC_W-1:0] energy,
    output logic [ACC_W-1:0] acc_new
);

    logic [ACC_W-1:0] acc_d [NUM_CAR];
    logic [ACC_W-1:0] acc_q [NUM_CAR];

    always_comb begin
        acc_d   = acc_q;
        acc_new = acc_q[upd_car] - (acc_q[upd_car] >> ACC_SHIFT)
                + (energy >> ACC_SHIFT);
        if (upd_en) begin
            acc_d[upd_car] = acc_new;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_CAR; k++) begin
                acc_q[k] <= '0;
            end
        end else begin
            acc_q <= acc_d;
        end
    end

endmodule

// File: rtl/iqpl_db_map.sv
module iqpl_db_map #(
    parameter int ACC_W = 32,
    parameter int ATT_W = 9
) (
    input  logic [ACC_W-1:0] acc,
    output logic [ATT_W-1:0] att
);
    import iqpl_pkg::*;

    localparam int EMPTY_ATT = QDB_PER_OCT * ACC_W;

    int                   msb;
    logic                 found;
    logic [FRAC_BITS-1:0] frac_idx;

    always_comb begin
        msb   = 0;
        found = 1'b0;
        for (int b = 0; b < ACC_W; b++) begin
            if (acc[b]) begin
                msb   = b;
                found = 1'b1;
            end
        end
        frac_idx = '0;
        for (int j = 0; j < FRAC_BITS; j++) begin
            if (msb > j) begin
                frac_idx[FRAC_BITS-1-j] = acc[msb-1-j];
            end
        end
        if (!found) begin
            att = ATT_W'(EMPTY_ATT);
        end else begin
            att = ATT_W'(QDB_PER_OCT * (ACC_W - 1 - msb) - int'(oct_frac(frac_idx)));
        end
    end

endmodule

// File: rtl/iqpl_corr.sv
module iqpl_corr #(
    parameter int GAIN_W = 8,
    parameter int LIM_W  = 10,
    parameter int OFF_W  = 8,
    parameter int ATT_W  = 9,
    parameter int CORR_W = 8,
    parameter int LIN_W  = 15
) (
    input  logic [GAIN_W-1:0]        gain,
    input  logic [LIM_W-1:0]         limit,
    input  logic signed [OFF_W-1:0]  offset,
    input  logic [ATT_W-1:0]         att,
    output logic [CORR_W-1:0]        corr_qdb,
    output logic [LIN_W-1:0]         lin_fac
);
    import iqpl_pkg::*;

    int headroom;
    int sel;
    int oct;
    int rem;

    always_comb begin
        // attenuation needed to stay below the ceiling
        headroom = int'(limit) - int'(att) - int'(offset);
        sel      = (headroom > int'(gain)) ? headroom : int'(gain);
        if (sel > QDB_MAX) begin
            sel = QDB_MAX;
        end
        corr_qdb = CORR_W'(sel);
        oct      = sel / QDB_PER_HALF;
        rem      = sel % QDB_PER_HALF;
        lin_fac  = LIN_W'(lin_base(5'(rem)) >> oct);
    end

endmodule

// File: rtl/iqpl_scale.sv
module iqpl_scale #(
    parameter int DATA_W = 16,
    parameter int LIN_W  = 15
) (
    input  logic signed [DATA_W-1:0] x,
    input  logic [LIN_W-1:0]         lin_fac,
    output logic signed [DATA_W-1:0] y
);

    localparam int PW   = DATA_W + LIN_W + 1;
    localparam int FRAC = DATA_W - 1;
    localparam logic signed [PW-1:0] HALF    = PW'(1) <<< (FRAC - 1);
    localparam logic signed [PW-1:0] POS_LIM = (PW'(1) <<< FRAC) - PW'(1);
    localparam logic signed [PW-1:0] NEG_LIM = -POS_LIM;

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] rnd;

    always_comb begin
        prod = x * $signed({1'b0, lin_fac});
        rnd  = (prod + HALF) >>> FRAC;
        if (rnd > POS_LIM) begin
            y = POS_LIM[DATA_W-1:0];
        end else if (rnd < NEG_LIM) begin
            y = NEG_LIM[DATA_W-1:0];
        end else begin
            y = rnd[DATA_W-1:0];
        end
    end

endmodule

// File: rtl/iq_power_limiter.sv
module iq_power_limiter #(
    parameter int DATA_W    = 16,
    parameter int NUM_CAR   = 4,
    parameter int ACC_SHIFT = 2,
    parameter int GAIN_W    = 8,
    parameter int LIM_W     = 10,
    parameter int OFF_W     = 8,
    localparam int CAR_W    = (NUM_CAR > 1) ? $clog2(NUM_CAR) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_valid,
    input  logic [CAR_W-1:0]                  in_car,
    input  logic signed [DATA_W-1:0]          in_i,
    input  logic signed [DATA_W-1:0]          in_q,
    input  logic [NUM_CAR-1:0][GAIN_W-1:0]    cfg_gain,
    input  logic [NUM_CAR-1:0][LIM_W-1:0]     cfg_limit,
    input  logic [NUM_CAR-1:0][OFF_W-1:0]     cfg_offset,
    output logic                              out_valid,
    output logic signed [DATA_W-1:0]          out_i,
    output logic signed [DATA_W-1:0]          out_q
);
    import iqpl_pkg::*;

    localparam int PIPE   = 6;
    localparam int ACC_W  = 2 * DATA_W;
    localparam int ATT_W  = $clog2(QDB_PER_OCT * ACC_W + 1);
    localparam int LIN_W  = DATA_W - 1;
    localparam int CORR_W = $clog2(QDB_MAX + 1);
    localparam int LANES  = 2;

    typedef struct packed {
        logic [PIPE-1:0]          vld;
        logic [CAR_W-1:0]         c1;
        logic [CAR_W-1:0]         c2;
        logic [CAR_W-1:0]         c3;
        logic [CAR_W-1:0]         c4;
        logic signed [DATA_W-1:0] i1;
        logic signed [DATA_W-1:0] q1;
        logic signed [DATA_W-1:0] i2;
        logic signed [DATA_W-1:0] q2;
        logic signed [DATA_W-1:0] i3;
        logic signed [DATA_W-1:0] q3;
        logic signed [DATA_W-1:0] i4;
        logic signed [DATA_W-1:0] q4;
        logic signed [DATA_W-1:0] i5;
        logic signed [DATA_W-1:0] q5;
        logic [ACC_W-1:0]         e2;
        logic [ACC_W-1:0]         a3;
        logic [ATT_W-1:0]         att4;
        logic [LIN_W-1:0]         lin5;
        logic signed [DATA_W-1:0] oi;
        logic signed [DATA_W-1:0] oq;
    } pipe_t;

    pipe_t st_d;
    pipe_t st_q;

    logic signed [ACC_W-1:0]  sq_i;
    logic signed [ACC_W-1:0]  sq_q;
    logic [ACC_W-1:0]         energy;
    logic [ACC_W-1:0]         acc_new;
    logic [ATT_W-1:0]         att_meas;
    logic [CORR_W-1:0]        corr_qdb;
    logic [LIN_W-1:0]         lin_fac;
    logic signed [DATA_W-1:0] lane_x [LANES];
    logic signed [DATA_W-1:0] lane_y [LANES];

    // stage 3: per-carrier average power (feedback held in the tracker)
    iqpl_pwr_track #(
        .NUM_CAR   (NUM_CAR),
        .ACC_W     (ACC_W),
        .ACC_SHIFT (ACC_SHIFT)
    ) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_en  (st_q.vld[1]),
        .upd_car (st_q.c2),
        .energy  (st_q.e2),
        .acc_new (acc_new)
    );

    // stage 4: power to quarter-dB
    iqpl_db_map #(
        .ACC_W (ACC_W),
        .ATT_W (ATT_W)
    ) u_db (
        .acc (st_q.a3),
        .att (att_meas)
    );

    // stage 5: max-select and back to linear
    iqpl_corr #(
        .GAIN_W (GAIN_W),
        .LIM_W  (LIM_W),
        .OFF_W  (OFF_W),
        .ATT_W  (ATT_W),
        .CORR_W (CORR_W),
        .LIN_W  (LIN_W)
    ) u_corr (
        .gain     (cfg_gain[st_q.c4]),
        .limit    (cfg_limit[st_q.c4]),
        .offset   ($signed(cfg_offset[st_q.c4])),
        .att      (st_q.att4),
        .corr_qdb (corr_qdb),
        .lin_fac  (lin_fac)
    );

    // stage 6: one multiplier lane per component
    assign lane_x[0] = st_q.i5;
    assign lane_x[1] = st_q.q5;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        iqpl_scale #(
            .DATA_W (DATA_W),
            .LIN_W  (LIN_W)
        ) u_scale (
            .x       (lane_x[l]),
            .lin_fac (st_q.lin5),
            .y       (lane_y[l])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = {st_q.vld[PIPE-2:0], in_valid};

        st_d.c1 = in_car;
        st_d.i1 = in_i;
        st_d.q1 = in_q;

        sq_i    = st_q.i1 * st_q.i1;
        sq_q    = st_q.q1 * st_q.q1;
        energy  = $unsigned(sq_i) + $unsigned(sq_q);
        st_d.c2 = st_q.c1;
        st_d.i2 = st_q.i1;
        st_d.q2 = st_q.q1;
        st_d.e2 = energy;

        st_d.c3 = st_q.c2;
        st_d.i3 = st_q.i2;
        st_d.q3 = st_q.q2;
        st_d.a3 = acc_new;

        st_d.c4   = st_q.c3;
        st_d.i4   = st_q.i3;
        st_d.q4   = st_q.q3;
        st_d.att4 = att_meas;

        st_d.i5   = st_q.i4;
        st_d.q5   = st_q.q4;
        st_d.lin5 = lin_fac;

        st_d.oi = st_q.vld[PIPE-2] ? lane_y[0] : '0;
        st_d.oq = st_q.vld[PIPE-2] ? lane_y[1] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld[PIPE-1];
    assign out_i     = st_q.oi;
    assign out_q     = st_q.oq;

endmodule

// File: rtl/iq_power_limiter_chk.sv
module iq_power_limiter_chk #(
    parameter int DATA_W = 16,
    parameter int CORR_W = 8,
    parameter int LIN_W  = 15
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic                     out_valid,
    input logic signed [DATA_W-1:0] out_i,
    input logic signed [DATA_W-1:0] out_q,
    input logic [CORR_W-1:0]        corr_qdb,
    input logic [LIN_W-1:0]         lin_fac
);

    localparam logic signed [DATA_W-1:0] MIN_VAL = {1'b1, {(DATA_W-1){1'b0}}};

    logic [2:0] since_rst;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 3'd7) begin
            since_rst <= since_rst + 3'd1;
        end
    end

    // R1: output valid follows input valid six edges later
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd6) |-> (out_valid == $past(in_valid, 6)));

    // R9: idle outputs are zero
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_i == '0 && out_q == '0));

    // R6: saturation keeps magnitude below one
    p_no_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_i != MIN_VAL && out_q != MIN_VAL));

    // R4: applied attenuation never exceeds 48 dB
    p_corr_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        corr_qdb <= CORR_W'(192));

    // R5: the linear factor never collapses to zero within the range
    p_lin_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lin_fac != '0);

    // R7: reset empties the output stage
    p_reset_r7: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

endmodule

bind iq_power_limiter iq_power_limiter_chk #(
    .DATA_W (DATA_W),
    .CORR_W (CORR_W),
    .LIN_W  (LIN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q),
    .corr_qdb  (corr_qdb),
    .lin_fac   (lin_fac)
);

// File: tb/iq_power_limiter_bench.sv
module iq_power_limiter_bench;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   in_valid = 1'b0;
    logic [1:0]             in_car = '0;
    logic signed [15:0]     in_i = '0;
    logic signed [15:0]     in_q = '0;
    logic [3:0][7:0]        cfg_gain = '0;
    logic [3:0][9:0]        cfg_limit = '0;
    logic [3:0][7:0]        cfg_offset = '0;
    logic                   out_valid;
    logic signed [15:0]     out_i;
    logic signed [15:0]     out_q;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    longint macc [4];
    logic   hv [64];
    int     hi [64];
    int     hq [64];
    string  ht [64];

    // {carrier, I, Q}
    localparam logic [33:0] VEC [16] = '{
        {2'd0, 16'sd8192,   -16'sd4096},
        {2'd1, 16'sd16384,  16'sd16384},
        {2'd2, 16'sd16384,  16'sd16384},
        {2'd2, 16'sd16384,  16'sd16384},
        {2'd3, -16'sd20000, 16'sd3000},
        {2'd0, 16'sd32767,  16'sd0},
        {2'd1, -16'sd12000, 16'sd25000},
        {2'd2, 16'sd30000,  -16'sd30000},
        {2'd2, 16'sd1000,   16'sd1000},
        {2'd3, 16'sd0,      16'sd0},
        {2'd0, -16'sd1,     16'sd1},
        {2'd1, 16'sd0,      -16'sd32767},
        {2'd2, -16'sd32768, 16'sd0},
        {2'd3, 16'sd12345,  -16'sd23456},
        {2'd3, 16'sd12345,  -16'sd23456},
        {2'd0, 16'sd5,      -16'sd5}
    };

    always #2.5 clk = ~clk;

    iq_power_limiter u_iq_power_limiter (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_car     (in_car),
        .in_i       (in_i),
        .in_q       (in_q),
        .cfg_gain   (cfg_gain),
        .cfg_limit  (cfg_limit),
        .cfg_offset (cfg_offset),
        .out_valid  (out_valid),
        .out_i      (out_i),
        .out_q      (out_q)
    );

    // R3 reference mapping
    function automatic int ref_att(longint acc);
        int p;
        int m;
        int fr [8] = '{0, 2, 4, 6, 7, 8, 10, 11};
        if (acc == 0) return 384;
        p = 0;
        for (int b = 31; b >= 0; b--) begin
            if (acc[b] && p == 0 && (acc >> b) == 1) p = b;
        end
        m = 0;
        for (int j = 1; j <= 3; j++) begin
            m = m * 2;
            if (p - j >= 0) m = m + int'(acc[p-j]);
        end
        return 12 * (31 - p) - fr[m];
    endfunction

    // R5 reference factor
    function automatic int ref_lin(int a);
        int s = a / 24;
        int r = a % 24;
        int b;
        if (r == 0) b = 32767;
        else b = $rtoi(32767.0 * (10.0 ** (-real'(r) / 80.0)) + 0.5);
        return b >> s;
    endfunction

    // R6 reference scaling
    function automatic int ref_out(int x, int l);
        longint p = longint'(x) * longint'(l) + 64'sd16384;
        longint r = p >>> 15;
        if (r > 32767) r = 32767;
        if (r < -32767) r = -32767;
        return int'(r);
    endfunction

    function automatic int absd(int a, int b);
        return (a > b) ? a - b : b - a;
    endfunction

    task automatic step(input logic v, input logic [1:0] c, input int ii,
                        input int qq, input logic rs, input string tag);
        int k;
        int g;
        int lim;
        int off;
        int sel;
        int l;
        longint e;
        @(negedge clk);
        if (cyc >= 6) begin
            k = (cyc - 6) % 64;
            n_chk++;
            if (hv[k]) begin
                if (out_valid !== 1'b1 || absd(int'(out_i), hi[k]) > 1 ||
                    absd(int'(out_q), hq[k]) > 1) begin
                    n_bad++;
                    $display("FAIL %s: got v=%0b i=%0d q=%0d, expected v=1 i=%0d q=%0d",
                             ht[k], out_valid, out_i, out_q, hi[k], hq[k]);
                end
            end else if (out_valid !== 1'b0 || out_i !== 16'sd0 || out_q !== 16'sd0) begin
                n_bad++;
                $display("FAIL R1/R9 idle: got v=%0b i=%0d q=%0d, expected v=0 i=0 q=0",
                         out_valid, out_i, out_q);
            end
        end
        rst_n    = rs;
        in_valid = v;
        in_car   = c;
        in_i     = 16'(ii);
        in_q     = 16'(qq);
        k        = cyc % 64;
        hv[k]    = v & rs;
        ht[k]    = tag;
        if (!rs) begin
            for (int z = 0; z < 64; z++) hv[z] = 1'b0;
            for (int z = 0; z < 4; z++) macc[z] = 0;
        end else if (v) begin
            e = longint'(ii) * ii + longint'(qq) * qq;
            macc[c] = macc[c] - (macc[c] >> 2) + (e >> 2);
            g   = int'(cfg_gain[c]);
            lim = int'(cfg_limit[c]);
            off = int'($signed(cfg_offset[c]));
            sel = lim - ref_att(macc[c]) - off;
            if (g > sel) sel = g;
            if (sel > 192) sel = 192;
            l = ref_lin(sel);
            hi[k] = ref_out(ii, l);
            hq[k] = ref_out(qq, l);
        end
        cyc++;
    endtask

    task automatic flush();
        for (int z = 0; z < 7; z++) step(1'b0, 2'd0, 0, 0, 1'b1, "R1 gap");
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        for (int z = 0; z < 4; z++) macc[z] = 0;
        for (int z = 0; z < 64; z++) hv[z] = 1'b0;
        // R8: distinct settings per carrier
        cfg_gain[0] = 8'd0;   cfg_limit[0] = 10'd0;   cfg_offset[0] = 8'd0;
        cfg_gain[1] = 8'd48;  cfg_limit[1] = 10'd0;   cfg_offset[1] = 8'd0;
        cfg_gain[2] = 8'd0;   cfg_limit[2] = 10'd120; cfg_offset[2] = 8'd0;
        cfg_gain[3] = 8'd10;  cfg_limit[3] = 10'd100; cfg_offset[3] = 8'hF8;

        // R7: outputs idle and zero during and after reset
        for (int z = 0; z < 8; z++) step(1'b0, 2'd0, 0, 0, 1'b0, "R7 reset");
        flush();

        // R2 R3 R4 R5 R6 R8: table walked back to back
        for (int v = 0; v < 16; v++) begin
            step(1'b1, VEC[v][33:32], int'($signed(VEC[v][31:16])),
                 int'($signed(VEC[v][15:0])), 1'b1, "R2/R3/R4/R5/R8 table");
        end
        flush();
        // same table with gaps: R1 latency holds with idle cycles between
        for (int v = 0; v < 16; v++) begin
            step(1'b1, VEC[v][33:32], int'($signed(VEC[v][31:16])),
                 int'($signed(VEC[v][15:0])), 1'b1, "R1 spaced");
            if (v % 3 == 0) step(1'b0, 2'd0, 0, 0, 1'b1, "R1 spaced idle");
        end
        flush();

        // R4: attenuation clamped at 192 from both select inputs
        cfg_gain[2]  = 8'd250;
        cfg_limit[0] = 10'd1000; cfg_offset[0] = 8'd127;
        flush();
        step(1'b1, 2'd2, 20000, -20000, 1'b1, "R4 gain clamp");
        step(1'b1, 2'd0, 30000, 30000, 1'b1, "R4 limit clamp");
        step(1'b1, 2'd1, 30000, 30000, 1'b1, "R8 untouched carrier");
        flush();

        // R6: full-scale negative input must not yield -32768
        cfg_limit[0] = 10'd0; cfg_offset[0] = 8'd0;
        flush();
        step(1'b1, 2'd0, -32768, -32768, 1'b1, "R6 negative full scale");
        step(1'b1, 2'd0, 32767, -32767, 1'b1, "R6 positive full scale");
        flush();

        // R7: reset mid-stream discards samples in flight and clears averages
        step(1'b1, 2'd2, 16384, 16384, 1'b1, "R7 before reset");
        step(1'b1, 2'd2, 16384, 16384, 1'b1, "R7 before reset");
        for (int z = 0; z < 3; z++) step(1'b0, 2'd0, 0, 0, 1'b0, "R7 reset");
        step(1'b1, 2'd2, 16384, 16384, 1'b1, "R7 first after reset");
        step(1'b1, 2'd3, -16384, 8192, 1'b1, "R2 fresh carrier");
        flush();

        finish_run();
    end

endmodule